// File: doc/BRIEF.md
# Wide Operand Store with 32-bit Host Port

This block holds the working data of a wide modular multiplier: four operand slots and one modulus, each `OP_W` bits wide, stored as `OP_W/32` words of 32 bits with word 0 the least significant. A host loads and inspects the slots one word at a time through a 9-bit word address. Address bit 8 chooses between the modulus and the operand slots. Address bits 7:6 name an operand slot, and bits 5:0 name the word inside it.

On the wide side, the multiplier sees the operand named by `op_sel` and the modulus as full-width vectors at all times. When it finishes a product, it pulses `res_load` with a destination code. The whole result then replaces that operand slot at the next clock edge.

Host reads honour a 2-bit part code, so the datapath can work on only the upper or lower portion of an operand. With the upper code (binary 10), operand reads are offset by one third of the operand, which is 16 words in the default 48-word configuration. A host write that lands in the same cycle as a result write is flagged on `host_collide`, and the result write wins.

The block has no state machine. The only sequential control is the registered read path and the registered collision flag.

Top module: `opmem_top`

## Requirements
- R1: A host write with `host_addr[8]`=1 stores `host_wdata` into modulus word `host_addr[5:0]` and leaves every operand slot unchanged. This holds even in a cycle where `res_load` is high.
- R2: A host write with `host_addr[8]`=0 stores into operand `host_addr[7:6]`, word `host_addr[5:0]`. Word k occupies bits [32k+31:32k]. A word index of `OP_W/32` or more is discarded.
- R3: `host_rdata` is registered. It shows the word addressed in a cycle after the next rising edge, so it is always within two cycles of the address.
- R4: With part code 10, an operand read returns word `host_addr[5:0] + OP_W/96`. With codes 11, 01 and 00 the offset is 0. Modulus reads are never offset. A read whose effective word is `OP_W/32` or more returns 0.
- R5: `op_wide` always equals operand `op_sel`, combinationally. It changes only after a write to that slot.
- R6: When `res_load` is high at a rising edge, `res_data` replaces operand `res_dest` in full.
- R7: `host_collide` is high in the cycle after an edge at which both `host_we` and `res_load` were high. It is low after every other edge.
- R8: When a host write and a result write occur at the same edge, the host write to any operand slot is discarded and the result is stored.
- R9: `mod_wide` always presents the full modulus.
- R10: Reset clears `host_collide` only. Operand and modulus contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host word write enable |
| host_addr | input | 9 | Host word address: bit 8 selects modulus, 7:6 operand, 5:0 word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_collide | output | 1 | Host write coincided with a result write |
| part_code | input | 2 | Part select: 11 full, 01 lower, 10 upper, 00 none |
| op_sel | input | 2 | Operand slot shown on `op_wide` |
| op_wide | output | OP_W | Selected operand, full width |
| mod_wide | output | OP_W | Modulus, full width |
| res_load | input | 1 | Store `res_data` into slot `res_dest` |
| res_dest | input | 2 | Destination slot of the result |
| res_data | input | OP_W | Full-width result |

## Verification
The bench builds the block with `OP_W` = 192, so each slot holds six words and the upper-part offset is two words. At that size, every word of every slot and of the modulus can be written and read back under all four part codes.

The sweep also reaches the reads that run past the top of a slot and must return zero, and the write to a word index just beyond the slot. The small width also makes it practical to compare the full `op_wide` and `mod_wide` vectors against a bench-side model after each phase, including result writes and collisions with both operand and modulus host writes.

// File: rtl/opmem_pkg.sv
package opmem_pkg;

    localparam int HOST_AW      = 9;
    localparam int HOST_DW      = 32;
    localparam int SLOT_SEL_W   = 2;
    localparam int WORD_FIELD_W = 6;
    localparam int RD_WORD_W    = WORD_FIELD_W + 1;

    typedef enum logic [1:0] {
        PART_NONE = 2'b00,
        PART_LOW  = 2'b01,
        PART_HIGH = 2'b10,
        PART_FULL = 2'b11
    } part_code_e;

endpackage

// File: rtl/opmem_host_decode.sv
module opmem_host_decode
    import opmem_pkg::*;
#(
    parameter int WORDS = 48
) (
    input  logic                     host_we,
    input  logic [HOST_AW-1:0]       host_addr,
    input  logic                     res_load,
    output logic                     mod_wr,
    output logic                     slot_wr,
    output logic [SLOT_SEL_W-1:0]    slot_idx,
    output logic [WORD_FIELD_W-1:0]  wr_word
);

    logic word_ok;

    always_comb begin
        wr_word  = host_addr[WORD_FIELD_W-1:0];
        slot_idx = host_addr[WORD_FIELD_W+SLOT_SEL_W-1:WORD_FIELD_W];
        word_ok  = (int'(wr_word) < WORDS);
        // modulus writes never conflict with the result path
        mod_wr   = host_we &&  host_addr[HOST_AW-1] && word_ok;
        // result write wins over any host operand write
        slot_wr  = host_we && !host_addr[HOST_AW-1] && word_ok && !res_load;
    end

endmodule

// File: rtl/opmem_read_index.sv
module opmem_read_index
    import opmem_pkg::*;
#(
    parameter int WORDS     = 48,
    parameter int UPPER_OFS = 16
) (
    input  logic [HOST_AW-1:0]    host_addr,
    input  logic [1:0]            part_code,
    output logic                  rd_is_mod,
    output logic [SLOT_SEL_W-1:0] rd_slot,
    output logic [RD_WORD_W-1:0]  rd_word,
    output logic                  rd_valid
);

    logic [RD_WORD_W-1:0] ofs;

    always_comb begin
        rd_is_mod = host_addr[HOST_AW-1];
        rd_slot   = host_addr[WORD_FIELD_W+SLOT_SEL_W-1:WORD_FIELD_W];
        unique case (part_code_e'(part_code))
            PART_HIGH: ofs = RD_WORD_W'(UPPER_OFS);
            PART_LOW:  ofs = '0;
            PART_FULL: ofs = '0;
            PART_NONE: ofs = '0;
            default:   ofs = '0;
        endcase
        if (rd_is_mod) ofs = '0;
        rd_word  = {1'b0, host_addr[WORD_FIELD_W-1:0]} + ofs;
        rd_valid = (int'(rd_word) < WORDS);
    end

endmodule

// File: rtl/opmem_slot_bank.sv
module opmem_slot_bank
    import opmem_pkg::*;
#(
    parameter int OP_W  = 1536,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     host_wr,
    input  logic [SLOT_SEL_W-1:0]    host_slot,
    input  logic [WORD_FIELD_W-1:0]  host_word,
    input  logic [HOST_DW-1:0]       host_wdata,
    input  logic                     res_wr,
    input  logic [SLOT_SEL_W-1:0]    res_slot,
    input  logic [OP_W-1:0]          res_data,
    input  logic [SLOT_SEL_W-1:0]    rd_slot,
    input  logic [RD_WORD_W-1:0]     rd_word,
    output logic [HOST_DW-1:0]       rd_data,
    input  logic [SLOT_SEL_W-1:0]    wide_sel,
    output logic [OP_W-1:0]          wide_out
);

    localparam int WORDS = OP_W / HOST_DW;

    logic [OP_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (res_wr && int'(res_slot) == g) begin
                slot_q[g] <= res_data;
            end else if (host_wr && int'(host_slot) == g) begin
                slot_q[g][int'(host_word)*HOST_DW +: HOST_DW] <= host_wdata;
            end
        end
    end

    always_comb begin
        int widx;
        widx     = (int'(rd_word) < WORDS) ? int'(rd_word) : 0;
        rd_data  = slot_q[rd_slot][widx*HOST_DW +: HOST_DW];
        wide_out = slot_q[wide_sel];
    end

endmodule

// File: rtl/opmem_modulus_reg.sv
module opmem_modulus_reg
    import opmem_pkg::*;
#(
    parameter int OP_W = 1536
) (
    input  logic                     clk,
    input  logic                     wr,
    input  logic [WORD_FIELD_W-1:0]  wr_word,
    input  logic [HOST_DW-1:0]       wdata,
    input  logic [RD_WORD_W-1:0]     rd_word,
    output logic [HOST_DW-1:0]       rd_data,
    output logic [OP_W-1:0]          wide_out
);

    localparam int WORDS = OP_W / HOST_DW;

    logic [OP_W-1:0] mod_q;

    always_ff @(posedge clk) begin
        if (wr) mod_q[int'(wr_word)*HOST_DW +: HOST_DW] <= wdata;
    end

    always_comb begin
        int widx;
        widx     = (int'(rd_word) < WORDS) ? int'(rd_word) : 0;
        rd_data  = mod_q[widx*HOST_DW +: HOST_DW];
        wide_out = mod_q;
    end

endmodule

// File: rtl/opmem_top.sv
module opmem_top
    import opmem_pkg::*;
#(
    parameter int OP_W = 1536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [8:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_collide,
    input  logic [1:0]        part_code,
    input  logic [1:0]        op_sel,
    output logic [OP_W-1:0]   op_wide,
    output logic [OP_W-1:0]   mod_wide,
    input  logic              res_load,
    input  logic [1:0]        res_dest,
    input  logic [OP_W-1:0]   res_data
);

    localparam int SLOTS     = 1 << SLOT_SEL_W;
    localparam int WORDS     = OP_W / HOST_DW;
    localparam int UPPER_OFS = WORDS / 3;

    logic                    mod_wr, slot_wr;
    logic [SLOT_SEL_W-1:0]   wr_slot;
    logic [WORD_FIELD_W-1:0] wr_word;
    logic                    rd_is_mod, rd_valid;
    logic [SLOT_SEL_W-1:0]   rd_slot;
    logic [RD_WORD_W-1:0]    rd_word;
    logic [HOST_DW-1:0]      slot_rd, mod_rd;

    opmem_host_decode #(.WORDS(WORDS)) u_dec (
        .host_we  (host_we),
        .host_addr(host_addr),
        .res_load (res_load),
        .mod_wr   (mod_wr),
        .slot_wr  (slot_wr),
        .slot_idx (wr_slot),
        .wr_word  (wr_word)
    );

    opmem_read_index #(.WORDS(WORDS), .UPPER_OFS(UPPER_OFS)) u_ridx (
        .host_addr(host_addr),
        .part_code(part_code),
        .rd_is_mod(rd_is_mod),
        .rd_slot  (rd_slot),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    opmem_slot_bank #(.OP_W(OP_W), .SLOTS(SLOTS)) u_bank (
        .clk       (clk),
        .host_wr   (slot_wr),
        .host_slot (wr_slot),
        .host_word (wr_word),
        .host_wdata(host_wdata),
        .res_wr    (res_load),
        .res_slot  (res_dest),
        .res_data  (res_data),
        .rd_slot   (rd_slot),
        .rd_word   (rd_word),
        .rd_data   (slot_rd),
        .wide_sel  (op_sel),
        .wide_out  (op_wide)
    );

    opmem_modulus_reg #(.OP_W(OP_W)) u_mod (
        .clk     (clk),
        .wr      (mod_wr),
        .wr_word (wr_word),
        .wdata   (host_wdata),
        .rd_word (rd_word),
        .rd_data (mod_rd),
        .wide_out(mod_wide)
    );

    always_ff @(posedge clk) begin
        if (!rd_valid)      host_rdata <= '0;
        else if (rd_is_mod) host_rdata <= mod_rd;
        else                host_rdata <= slot_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) host_collide <= 1'b0;
        else     host_collide <= host_we && res_load;
    end

endmodule

// File: rtl/opmem_checker.sv
module opmem_checker #(
    parameter int OP_W = 1536
) (
    input logic            clk,
    input logic            rst,
    input logic            host_we,
    input logic [8:0]      host_addr,
    input logic [31:0]     host_wdata,
    input logic            host_collide,
    input logic [1:0]      op_sel,
    input logic [OP_W-1:0] op_wide,
    input logic [OP_W-1:0] mod_wide,
    input logic            res_load,
    input logic [1:0]      res_dest,
    input logic [OP_W-1:0] res_data
);

    localparam int WORDS = OP_W / 32;

    logic [5:0]  prev_word;
    logic [31:0] mod_word_at_prev;

    always_ff @(posedge clk) prev_word <= host_addr[5:0];

    always_comb mod_word_at_prev = 32'(mod_wide >> (32 * int'(prev_word)));

    assert_collide_set_R7: assert property (@(posedge clk) disable iff (rst)
        (host_we && res_load) |=> host_collide);

    assert_collide_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !(host_we && res_load) |=> !host_collide);

    assert_result_store_R6: assert property (@(posedge clk) disable iff (rst)
        (res_load && res_dest == op_sel) ##1 $stable(op_sel) |-> op_wide == $past(res_data));

    assert_mod_write_R1: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr[8] && int'(host_addr[5:0]) < WORDS) |=> mod_word_at_prev == $past(host_wdata));

    assert_wide_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!host_we && !res_load) ##1 $stable(op_sel) |-> $stable(op_wide));

endmodule

bind opmem_top opmem_checker #(.OP_W(OP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_collide(host_collide),
    .op_sel      (op_sel),
    .op_wide     (op_wide),
    .mod_wide    (mod_wide),
    .res_load    (res_load),
    .res_dest    (res_dest),
    .res_data    (res_data)
);

// File: tb/opmem_top_tb.sv
module opmem_top_tb_top;

    localparam int  OP_W   = 192;
    localparam int  WORDS  = OP_W / 32;
    localparam int  UOFS   = WORDS / 3;
    localparam time CLK_T  = 10ns;

    logic            clk = 1'b0;
    logic            rst;
    logic            host_we;
    logic [8:0]      host_addr;
    logic [31:0]     host_wdata;
    logic [31:0]     host_rdata;
    logic            host_collide;
    logic [1:0]      part_code;
    logic [1:0]      op_sel;
    logic [OP_W-1:0] op_wide;
    logic [OP_W-1:0] mod_wide;
    logic            res_load;
    logic [1:0]      res_dest;
    logic [OP_W-1:0] res_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_slot [4][WORDS];
    logic [31:0] m_mod  [WORDS];

    always #(CLK_T/2) clk = ~clk;

    opmem_top #(.OP_W(OP_W)) dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_collide(host_collide),
        .part_code(part_code), .op_sel(op_sel), .op_wide(op_wide), .mod_wide(mod_wide),
        .res_load(res_load), .res_dest(res_dest), .res_data(res_data)
    );

    function automatic logic [31:0] pat(int s, int w, int seed);
        return {8'hA5 ^ 8'(seed), 8'(s), 8'(w * 7 + seed), 8'h3C};
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic checkw(string req, logic [OP_W-1:0] act, logic [OP_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [OP_W-1:0] slot_vec(int s);
        logic [OP_W-1:0] v;
        for (int w = 0; w < WORDS; w++) v[w*32 +: 32] = m_slot[s][w];
        return v;
    endfunction

    function automatic logic [OP_W-1:0] mod_vec();
        logic [OP_W-1:0] v;
        for (int w = 0; w < WORDS; w++) v[w*32 +: 32] = m_mod[w];
        return v;
    endfunction

    task automatic host_write(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(string req, logic [8:0] a, logic [31:0] exp);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        check32(req, host_rdata, exp);
    endtask

    task automatic check_all_wide(string req);
        for (int s = 0; s < 4; s++) begin
            op_sel = 2'(s);
            #1;
            checkw(req, op_wide, slot_vec(s));
        end
        checkw("R9 modulus wide", mod_wide, mod_vec());
    endtask

    initial begin
        #(CLK_T * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        part_code = 2'b11; op_sel = '0; res_load = 1'b0; res_dest = '0; res_data = '0;
        repeat (3) @(negedge clk);
        check32("R10 collide low in reset", {31'd0, host_collide}, 32'd0);
        rst = 1'b0;

        // R2: fill every operand word; R1: fill modulus
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < WORDS; w++) begin
                m_slot[s][w] = pat(s, w, 1);
                host_write({1'b0, 2'(s), 6'(w)}, m_slot[s][w]);
            end
        for (int w = 0; w < WORDS; w++) begin
            m_mod[w] = pat(7, w, 2);
            host_write({1'b1, 2'b00, 6'(w)}, m_mod[w]);
        end
        // R2: out-of-range word index discarded
        host_write({1'b0, 2'd0, 6'(WORDS)}, 32'hDEAD_BEEF);
        check_all_wide("R2 R5 wide after fill");

        // R3 R4: reads under each part code
        for (int pc = 0; pc < 4; pc++) begin
            part_code = 2'(pc);
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < WORDS; w++) begin
                    int eff;
                    eff = (pc == 2) ? w + UOFS : w;
                    host_read("R3 R4 operand read", {1'b0, 2'(s), 6'(w)},
                              (eff < WORDS) ? m_slot[s][eff] : 32'd0);
                end
            for (int w = 0; w < WORDS; w++)
                host_read("R1 R4 modulus read no offset", {1'b1, 2'b00, 6'(w)}, m_mod[w]);
        end
        part_code = 2'b11;
        host_read("R4 beyond end reads zero", {1'b0, 2'd1, 6'(WORDS)}, 32'd0);

        // R6: result write into each slot
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < WORDS; w++) m_slot[s][w] = pat(s, w, 9);
            @(negedge clk);
            res_load = 1'b1; res_dest = 2'(s); res_data = slot_vec(s);
            @(negedge clk);
            res_load = 1'b0;
            check32("R7 no collide on lone result", {31'd0, host_collide}, 32'd0);
        end
        check_all_wide("R6 wide after result writes");

        // R7 R8: host operand write collides with result to another slot
        for (int w = 0; w < WORDS; w++) m_slot[2][w] = pat(2, w, 20);
        @(negedge clk);
        host_we = 1'b1; host_addr = {1'b0, 2'd1, 6'd0}; host_wdata = 32'h1234_5678;
        res_load = 1'b1; res_dest = 2'd2; res_data = slot_vec(2);
        @(negedge clk);
        host_we = 1'b0; res_load = 1'b0;
        check32("R7 collide set", {31'd0, host_collide}, 32'd1);
        @(negedge clk);
        check32("R7 collide clears", {31'd0, host_collide}, 32'd0);
        host_read("R8 host operand write dropped", {1'b0, 2'd1, 6'd0}, m_slot[1][0]);

        // R8: collision on the same slot, result wins
        for (int w = 0; w < WORDS; w++) m_slot[3][w] = pat(3, w, 30);
        @(negedge clk);
        host_we = 1'b1; host_addr = {1'b0, 2'd3, 6'd1}; host_wdata = 32'hFFFF_0000;
        res_load = 1'b1; res_dest = 2'd3; res_data = slot_vec(3);
        @(negedge clk);
        host_we = 1'b0; res_load = 1'b0;
        check32("R7 collide same slot", {31'd0, host_collide}, 32'd1);
        host_read("R8 result wins same slot", {1'b0, 2'd3, 6'd1}, m_slot[3][1]);

        // R1: modulus write during a result write still lands
        for (int w = 0; w < WORDS; w++) m_slot[0][w] = pat(0, w, 40);
        m_mod[2] = 32'hCAFE_F00D;
        @(negedge clk);
        host_we = 1'b1; host_addr = {1'b1, 2'b00, 6'd2}; host_wdata = m_mod[2];
        res_load = 1'b1; res_dest = 2'd0; res_data = slot_vec(0);
        @(negedge clk);
        host_we = 1'b0; res_load = 1'b0;
        check32("R7 collide on modulus write", {31'd0, host_collide}, 32'd1);
        check_all_wide("R1 R8 R9 wide after collisions");

        // R10: reset keeps storage
        @(negedge clk);
        host_we = 1'b1; res_load = 1'b1; host_addr = {1'b1, 2'b00, 6'd2}; host_wdata = m_mod[2];
        @(negedge clk);
        host_we = 1'b0; res_load = 1'b0; rst = 1'b1;
        @(negedge clk);
        check32("R10 reset clears collide", {31'd0, host_collide}, 32'd0);
        rst = 1'b0;
        check_all_wide("R10 storage kept over reset");
        host_read("R10 read after reset", {1'b0, 2'd2, 6'd5}, m_slot[2][5]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule